// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer for a system controller, reached through a 16-bit register bus over a 32-byte window. Software loads a timeout, measured in coarse ticks, into an initial-value register. It releases the counter by clearing a halt bit, and it services the watchdog by writing the reload register. The counter moves down by one on each cycle where the external tick strobe is high. In the intended system that strobe arrives every 0.6 s.

Expiry happens in two stages. The first time the counter runs out, the block sets a sticky first-timeout flag and reloads itself. If that flag is enabled, the block also raises a management interrupt. If the counter runs out again before software clears the flag, the block sets a second-timeout flag and issues a one-cycle system reset request. A no-reboot bit can block that request. All status flags are cleared by writing one to them.

The bus has no back-pressure. Every access completes in the cycle it is presented. Read data is combinational from the current address. A write takes effect at the clock edge where `reg_sel` and `reg_we` are both high. Each byte lane is written only when its enable is set.

Top module: `wdt_two_stage`

## Requirements
- R1: Out of reset, the block starts in this state:
  - halt is 1 (bit 11 at offset 0x08).
  - no-reboot is 1 (bit 5 at offset 0x0C).
  - interrupt enable is 0 (bit 13 at offset 0x0C).
  - The initial value (offset 0x12) and the count both equal INIT_TICKS.
  - All status flags are 0, and `smi_irq` and `rst_req` are low.
- R2: While the halt bit is 1, tick strobes leave the count unchanged. While it is 0, each strobe lowers the count by one. The halt bit reads back as written.
- R3: The initial-value field is bits [9:0] at offset 0x12. A write that would leave the field below MIN_LOAD (0 to 3) keeps the previous field. Bits [15:10] of that register are stored and read back as written in every case.
- R4: Any write to offset 0x00 loads the counter with the initial value. A read of 0x00 returns the count in bits [9:0] and zero above.
- R5: A reload write and a tick strobe in the same cycle load the counter and the tick is dropped.
- R6: A tick that finds the running counter at 0 is an expiry. The counter reloads from the initial value and the first-timeout flag (bit 3 at offset 0x04) is set. One full period is therefore initial value + 1 ticks.
- R7: An expiry while the first-timeout flag is already set sets the second-timeout flag (bit 1 at offset 0x06). If no-reboot is 0, it also drives `rst_req` high for exactly one cycle and sets the boot flag (bit 2 at offset 0x06).
- R8: While no-reboot is 1, a second expiry sets the second-timeout flag only. `rst_req` stays low and the boot flag is not set.
- R9: Each status flag is cleared by writing 1 to its bit. Writing 0 leaves it unchanged.
- R10: `smi_irq` is high exactly when the first-timeout flag is set and interrupt enable is 1.
- R11: `reg_be[0]` enables bits [7:0] of a write and `reg_be[1]` enables bits [15:8]. Bits in a disabled lane keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Access strobe for the register window |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset inside the window; registers sit at even offsets |
| reg_be | input | 2 | Byte-lane enables for writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| tick_en | input | 1 | One-cycle tick strobe that advances the counter |
| smi_irq | output | 1 | Management interrupt, level |
| rst_req | output | 1 | System reset request, one-cycle pulse |

## Verification
The bench builds the block with its default parameters: a 10-bit counter, INIT_TICKS of 50 and MIN_LOAD of 4. It then programs an initial value of 5, so a full period takes six strobes. Because the bench drives the tick strobe itself, first expiries, second expiries with and without no-reboot, and a reload that collides with a tick can all be reached in a few hundred cycles. Loading values just below and above MIN_LOAD, and writing single byte lanes, exercises the ignore rule and the lane masking on the same register.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned WIN_AW = 5;

  // register offsets inside the 32-byte window
  localparam logic [WIN_AW-1:0] OFS_RELOAD = 5'h00;
  localparam logic [WIN_AW-1:0] OFS_STAT_A = 5'h04;
  localparam logic [WIN_AW-1:0] OFS_STAT_B = 5'h06;
  localparam logic [WIN_AW-1:0] OFS_CTRL   = 5'h08;
  localparam logic [WIN_AW-1:0] OFS_CFG    = 5'h0C;
  localparam logic [WIN_AW-1:0] OFS_INIT   = 5'h12;

  // bit positions
  localparam int unsigned HALT_BIT     = 11;
  localparam int unsigned FIRST_BIT    = 3;
  localparam int unsigned SECOND_BIT   = 1;
  localparam int unsigned BOOT_BIT     = 2;
  localparam int unsigned NOREBOOT_BIT = 5;
  localparam int unsigned IRQEN_BIT    = 13;

  typedef struct packed {
    logic first;
    logic second;
    logic boot;
  } wdt_flags_t;

  typedef struct packed {
    logic reload;
    logic clr_first;
    logic clr_second;
    logic clr_boot;
  } wdt_cmd_t;
endpackage

// File: rtl/wdt2_regs.sv
module wdt2_regs
  import wdt2_pkg::*;
#(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned INIT_TICKS = 50,
  parameter int unsigned MIN_LOAD   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [WIN_AW-1:0] reg_addr,
  input  logic [BUS_W/8-1:0] reg_be,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic [CNT_W-1:0]  count,
  input  wdt_flags_t        flags,
  output logic              halt,
  output logic              no_reboot,
  output logic              irq_en,
  output logic [CNT_W-1:0]  init_val,
  output wdt_cmd_t          cmd
);
  localparam int unsigned LANES = BUS_W / 8;

  logic             wr;
  logic [BUS_W-1:0] lane_mask;
  logic [BUS_W-1:0] init_q;
  logic [BUS_W-1:0] init_merge;
  logic             init_ok;

  assign wr = reg_sel & reg_we;

  // expand byte enables into a bit mask
  generate
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign lane_mask[b*8 +: 8] = {8{reg_be[b]}};
    end
  endgenerate

  assign init_merge = (reg_wdata & lane_mask) | (init_q & ~lane_mask);
  assign init_ok    = init_merge[CNT_W-1:0] >= CNT_W'(MIN_LOAD);
  assign init_val   = init_q[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt      <= 1'b1;
      no_reboot <= 1'b1;
      irq_en    <= 1'b0;
      init_q    <= BUS_W'(INIT_TICKS);
    end else begin
      if (wr && reg_addr == OFS_CTRL && lane_mask[HALT_BIT])
        halt <= reg_wdata[HALT_BIT];
      if (wr && reg_addr == OFS_CFG && lane_mask[NOREBOOT_BIT])
        no_reboot <= reg_wdata[NOREBOOT_BIT];
      if (wr && reg_addr == OFS_CFG && lane_mask[IRQEN_BIT])
        irq_en <= reg_wdata[IRQEN_BIT];
      if (wr && reg_addr == OFS_INIT && (|reg_be))
        init_q <= init_ok ? init_merge
                          : {init_merge[BUS_W-1:CNT_W], init_q[CNT_W-1:0]};
    end
  end

  // one-cycle commands toward counter and flags
  always_comb begin
    cmd.reload     = wr && reg_addr == OFS_RELOAD && (|reg_be);
    cmd.clr_first  = wr && reg_addr == OFS_STAT_A && lane_mask[FIRST_BIT]
                     && reg_wdata[FIRST_BIT];
    cmd.clr_second = wr && reg_addr == OFS_STAT_B && lane_mask[SECOND_BIT]
                     && reg_wdata[SECOND_BIT];
    cmd.clr_boot   = wr && reg_addr == OFS_STAT_B && lane_mask[BOOT_BIT]
                     && reg_wdata[BOOT_BIT];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_RELOAD: reg_rdata[CNT_W-1:0] = count;
      OFS_STAT_A: reg_rdata[FIRST_BIT] = flags.first;
      OFS_STAT_B: begin
        reg_rdata[SECOND_BIT] = flags.second;
        reg_rdata[BOOT_BIT]   = flags.boot;
      end
      OFS_CTRL:   reg_rdata[HALT_BIT] = halt;
      OFS_CFG: begin
        reg_rdata[NOREBOOT_BIT] = no_reboot;
        reg_rdata[IRQEN_BIT]    = irq_en;
      end
      OFS_INIT:   reg_rdata = init_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter #(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned INIT_TICKS = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             halt,
  input  logic             reload,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic step;

  // reload write wins over a tick in the same cycle
  assign step   = tick_en & ~halt & ~reload;
  assign expire = step & (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= CNT_W'(INIT_TICKS);
    else if (reload || expire)
      count <= init_val;
    else if (step)
      count <= count - 1'b1;
  end
endmodule

// File: rtl/wdt2_expiry.sv
module wdt2_expiry
  import wdt2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic       no_reboot,
  input  wdt_cmd_t   cmd,
  output wdt_flags_t flags,
  output logic       rst_req
);
  logic second_hit;

  assign second_hit = expire & flags.first;

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      rst_req <= 1'b0;
    end else begin
      flags.first  <= (flags.first  & ~cmd.clr_first)  | expire;
      flags.second <= (flags.second & ~cmd.clr_second) | second_hit;
      flags.boot   <= (flags.boot   & ~cmd.clr_boot)   | (second_hit & ~no_reboot);
      rst_req      <= second_hit & ~no_reboot;
    end
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt2_pkg::*;
#(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned INIT_TICKS = 50,
  parameter int unsigned MIN_LOAD   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_sel,
  input  logic         reg_we,
  input  logic [4:0]   reg_addr,
  input  logic [1:0]   reg_be,
  input  logic [15:0]  reg_wdata,
  output logic [15:0]  reg_rdata,
  input  logic         tick_en,
  output logic         smi_irq,
  output logic         rst_req
);
  logic             halt;
  logic             no_reboot;
  logic             irq_en;
  logic [CNT_W-1:0] init_val;
  logic [CNT_W-1:0] count;
  logic             expire;
  logic             do_reload;
  logic             sts_first;
  logic             sts_second;
  wdt_cmd_t         cmd;
  wdt_flags_t       flags;

  wdt2_regs #(
    .CNT_W(CNT_W), .INIT_TICKS(INIT_TICKS), .MIN_LOAD(MIN_LOAD)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .count(count), .flags(flags),
    .halt(halt), .no_reboot(no_reboot), .irq_en(irq_en),
    .init_val(init_val), .cmd(cmd)
  );

  wdt2_counter #(
    .CNT_W(CNT_W), .INIT_TICKS(INIT_TICKS)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt(halt),
    .reload(cmd.reload), .init_val(init_val),
    .count(count), .expire(expire)
  );

  wdt2_expiry u_exp (
    .clk(clk), .rst_n(rst_n), .expire(expire), .no_reboot(no_reboot),
    .cmd(cmd), .flags(flags), .rst_req(rst_req)
  );

  assign do_reload  = cmd.reload;
  assign sts_first  = flags.first;
  assign sts_second = flags.second;
  assign smi_irq    = flags.first & irq_en;
endmodule

// File: rtl/wdt2_checker.sv
module wdt2_checker #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned MIN_LOAD = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             halt,
  input logic             no_reboot,
  input logic             do_reload,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] init_val,
  input logic             sts_first,
  input logic             sts_second,
  input logic             rst_req
);
  // R2
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !do_reload) |=> count == $past(count));

  // R3
  init_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_val >= CNT_W'(MIN_LOAD));

  // R5
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_reload |=> count == $past(init_val));

  // R6
  expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !halt && !do_reload && count == '0)
      |=> (count == $past(init_val) && sts_first));

  // R7
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R7
  rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> sts_second);

  // R8
  noreboot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(no_reboot));
endmodule

bind wdt_two_stage wdt2_checker #(.CNT_W(CNT_W), .MIN_LOAD(MIN_LOAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt(halt),
  .no_reboot(no_reboot), .do_reload(do_reload), .count(count),
  .init_val(init_val), .sts_first(sts_first), .sts_second(sts_second),
  .rst_req(rst_req)
);

// File: tb/wdt_two_stage_bench.sv
module wdt_two_stage_bench;
  import wdt2_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [1:0]  reg_be = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        tick_en = 1'b0;
  logic        smi_irq;
  logic        rst_req;

  int checks = 0;
  int fails = 0;
  int rst_cycles = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  wdt_two_stage u_wdt_two_stage (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tick_en(tick_en), .smi_irq(smi_irq),
    .rst_req(rst_req)
  );

  always #4 clk = ~clk;

  // count cycles with the reset request high
  always @(posedge clk) begin
    #1;
    if (rst_req) rst_cycles++;
  end

  // monitor: compare each read against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (reg_sel && !reg_we) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL unexpected read act=%h exp=none", reg_rdata);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (reg_rdata !== e) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", t, reg_rdata, e);
          end
        end
      end
    end
  end

  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_sel = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0; reg_be = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] e);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", t, act, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 smi_irq", 16'(smi_irq), 16'h0);
    chk("R1 rst_req", 16'(rst_req), 16'h0);
    rd(OFS_CTRL,   16'h0800, "R1 ctrl");
    rd(OFS_CFG,    16'h0020, "R1 cfg");
    rd(OFS_INIT,   16'd50,   "R1 init");
    rd(OFS_RELOAD, 16'd50,   "R1 count");
    rd(OFS_STAT_A, 16'h0,    "R1 stat_a");
    rd(OFS_STAT_B, 16'h0,    "R1 stat_b");

    // R2 halted counter ignores ticks
    ticks(3);
    rd(OFS_RELOAD, 16'd50, "R2 halted count");

    // R3 small loads ignored, upper bits stored
    wr(OFS_INIT, 16'h0002, 2'b11);
    rd(OFS_INIT, 16'd50, "R3 load 2 ignored");
    wr(OFS_INIT, 16'hFC05, 2'b11);
    rd(OFS_INIT, 16'hFC05, "R3 load 5 with upper bits");
    wr(OFS_INIT, 16'h0003, 2'b11);
    rd(OFS_INIT, 16'h0005, "R3 load 3 keeps field, upper written");

    // R4 reload write
    wr(OFS_RELOAD, 16'h0000, 2'b11);
    rd(OFS_RELOAD, 16'd5, "R4 count after reload");

    // R2 running counter
    wr(OFS_CTRL, 16'h0000, 2'b11);
    rd(OFS_CTRL, 16'h0000, "R2 halt readback");
    ticks(2);
    rd(OFS_RELOAD, 16'd3, "R2 count after two ticks");

    // R5 reload and tick together
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = OFS_RELOAD; reg_be = 2'b11;
    reg_wdata = 16'h0; tick_en = 1'b1;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0; reg_be = '0; tick_en = 1'b0;
    rd(OFS_RELOAD, 16'd5, "R5 reload wins over tick");

    // R6 / R10 first expiry with interrupt enabled
    wr(OFS_CFG, 16'h2020, 2'b11);
    ticks(5);
    rd(OFS_RELOAD, 16'd0, "R6 count at zero");
    rd(OFS_STAT_A, 16'h0, "R6 no flag before expiry");
    chk("R10 irq before expiry", 16'(smi_irq), 16'h0);
    ticks(1);
    rd(OFS_STAT_A, 16'h0008, "R6 first flag");
    rd(OFS_RELOAD, 16'd5, "R6 count reloaded");
    chk("R10 irq after expiry", 16'(smi_irq), 16'h1);

    // R9 clear by writing one
    wr(OFS_STAT_A, 16'h0008, 2'b11);
    rd(OFS_STAT_A, 16'h0, "R9 first cleared");
    chk("R10 irq after clear", 16'(smi_irq), 16'h0);
    ticks(6);
    rd(OFS_STAT_A, 16'h0008, "R6 first flag again");
    wr(OFS_STAT_A, 16'h0000, 2'b11);
    rd(OFS_STAT_A, 16'h0008, "R9 write zero keeps flag");

    // R8 second expiry blocked by no-reboot
    ticks(6);
    rd(OFS_STAT_B, 16'h0002, "R8 second flag, no boot flag");
    chk("R8 no reset request", 16'(rst_cycles), 16'd0);

    // R7 second expiry with reboot allowed
    wr(OFS_STAT_B, 16'h0006, 2'b11);
    rd(OFS_STAT_B, 16'h0, "R9 stat_b cleared");
    wr(OFS_CFG, 16'h0000, 2'b11);
    chk("R10 irq gated off", 16'(smi_irq), 16'h0);
    ticks(6);
    rd(OFS_STAT_B, 16'h0006, "R7 second and boot flags");
    chk("R7 reset pulse width", 16'(rst_cycles), 16'd1);

    // R9 selective clear
    wr(OFS_STAT_B, 16'h0004, 2'b11);
    rd(OFS_STAT_B, 16'h0002, "R9 only boot cleared");
    wr(OFS_STAT_B, 16'h0002, 2'b11);
    rd(OFS_STAT_B, 16'h0, "R9 second cleared");

    // R2 / R11 halt and lane masking
    wr(OFS_CTRL, 16'h0800, 2'b11);
    rd(OFS_CTRL, 16'h0800, "R2 halt set");
    ticks(3);
    rd(OFS_RELOAD, 16'd5, "R2 halted again");
    wr(OFS_CTRL, 16'h0000, 2'b01);
    rd(OFS_CTRL, 16'h0800, "R11 low lane leaves halt");
    ticks(2);
    rd(OFS_RELOAD, 16'd5, "R11 still halted");
    wr(OFS_INIT, 16'h0100, 2'b10);
    rd(OFS_INIT, 16'h0105, "R11 high lane only");

    @(negedge clk);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard act=%0d exp=0 pending reads", exp_q.size());
    end
    finish_run();
  end
endmodule